// File: doc/BRIEF.md
# Double Late Write Synchronous SRAM

A clocked single-port memory that decodes one command on every rising clock edge. A command is made from five things: an active-low chip enable, a set of bank-select inputs that are compared against matching polarity inputs, an advance input, an active-low write enable and active-low per-lane byte enables. A new access loads an external address. A cycle with advance high continues the previous operation, and an internal counter steps the two low address bits through a burst of up to four beats.

Reads are pipelined. The word addressed at edge k is registered at that edge and stays on `dout` for the following cycle, while `dout_oe` is high. Writes are late by two edges. The lane mask is taken at the command edge, and the data on `din` is taken two edges later. A read that is sampled on the same edge as a write's data capture, at the same address, returns the merged new word. `echo_en` marks the cycles in which the echo clock would run. It drops only after a bank deselect.

Top module: `dlw_sram`

## Requirements
- R1: With advance low and any bank-select bit differing from its polarity bit, the command is a bank deselect, whatever `cs_n` is. After that edge, `dout_oe` and `echo_en` are both low.
- R2: With advance low, all bank-select bits matching and `cs_n` high, the command is a deselect. After that edge, `dout_oe` is low and `echo_en` is high.
- R3: With advance low, banks matching, `cs_n` low and `we_n` high, the command is a read of `addr`. After that edge, `dout_oe` is high, `echo_en` is high and `dout` holds the stored word.
- R4: With advance low, banks matching, `cs_n` low and `we_n` low, the command is a write of `addr`. After that edge, `dout_oe` is low and `echo_en` is high. The word on `din` at the second following edge is stored.
- R5: Lane i covers bits [9i+8:9i]. A write or write continue stores only the lanes whose `be_n` bit was low at its command edge. The other lanes keep their old contents.
- R6: A write or write continue with every `be_n` bit high stores nothing. Its address is still loaded or incremented.
- R7: With advance high, the previous operation repeats at an address whose two low bits are incremented modulo 4, with the upper bits unchanged. The fourth continue returns to the base address.
- R8: A continue cycle leaves `dout_oe` and `echo_en` at the values that the operation it continues produced.
- R9: A read sampled on the edge where a pending write's data is captured, at the same address, returns the new data in the enabled lanes. A write whose data comes later is not yet visible.
- R10: After reset, `dout_oe` and `echo_en` are low, and a continue issued first behaves as a bank deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip enable |
| bank_sel | input | BANKS | Bank-select inputs |
| bank_pol | input | BANKS | Polarity that each bank-select bit must equal |
| adv | input | 1 | High: continue the burst; low: new command |
| we_n | input | 1 | Active-low write enable for a new command |
| be_n | input | LANES | Active-low lane enables |
| addr | input | ADDR_W | External word address |
| din | input | LANES*LANE_W | Write data, taken two edges after its command |
| dout | output | LANES*LANE_W | Read data |
| dout_oe | output | 1 | Read data is being driven |
| echo_en | output | 1 | Echo clock enable |

## Verification
A wrong decode state shows on `dout_oe` and `echo_en` in the cycle right after the command edge, so every command is checked one cycle later. A wrong burst counter or a misrouted late write does not show until the affected word is read back, which happens one cycle after that read's edge. For this reason the whole array is filled and then read back in wrapping bursts. Stale bypass data shows only when a read and a data capture fall on the same edge, and the bench creates exactly that alignment.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
   typedef enum logic [1:0] {
      OP_BDES  = 2'd0,
      OP_DESL  = 2'd1,
      OP_READ  = 2'd2,
      OP_WRITE = 2'd3
   } dlw_op_e;
endpackage

// File: rtl/dlw_cmd.sv
module dlw_cmd
   import dlw_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              bank_ok,
   input  logic              adv,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr_in,
   output dlw_op_e           cur_op,
   output logic [ADDR_W-1:0] cur_addr
);
   dlw_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_inc;

   // Burst step: low two bits wrap modulo four, upper bits are held
   generate
      if (ADDR_W == 2) begin : g_inc_narrow
         assign addr_inc = addr_q + 2'd1;
      end else begin : g_inc_wide
         assign addr_inc = {addr_q[ADDR_W-1:2], addr_q[1:0] + 2'd1};
      end
   endgenerate

   always_comb begin
      cur_op   = op_q;
      cur_addr = addr_inc;
      if (!adv) begin
         cur_addr = addr_in;
         if (!bank_ok)   cur_op = OP_BDES;
         else if (cs_n)  cur_op = OP_DESL;
         else if (we_n)  cur_op = OP_READ;
         else            cur_op = OP_WRITE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= OP_BDES;
         addr_q <= '0;
      end else begin
         op_q   <= cur_op;
         addr_q <= cur_addr;
      end
   end
endmodule

// File: rtl/dlw_wpipe.sv
module dlw_wpipe #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [LANES-1:0]  be_n_in,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_lane
);
   localparam int STAGES = 2;

   logic              vld_q  [STAGES];
   logic [ADDR_W-1:0] addr_q [STAGES];
   logic [LANES-1:0]  lane_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            vld_q[s]  <= 1'b0;
            addr_q[s] <= '0;
            lane_q[s] <= '0;
         end
      end else begin
         // An all-high lane mask makes an abort: nothing reaches the array
         vld_q[0]  <= issue && (|(~be_n_in));
         addr_q[0] <= addr_in;
         lane_q[0] <= ~be_n_in;
         for (int s = 1; s < STAGES; s++) begin
            vld_q[s]  <= vld_q[s-1];
            addr_q[s] <= addr_q[s-1];
            lane_q[s] <= lane_q[s-1];
         end
      end
   end

   assign wr_en   = vld_q[STAGES-1];
   assign wr_addr = addr_q[STAGES-1];
   assign wr_lane = lane_q[STAGES-1];
endmodule

// File: rtl/dlw_array.sv
module dlw_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [LANES-1:0]          wlane,
   input  logic [LANES*LANE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*LANE_W-1:0]   rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (we && wlane[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
         end
         assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
   import dlw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int BANKS  = 2,
   parameter bit BYPASS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic [BANKS-1:0]         bank_sel,
   input  logic [BANKS-1:0]         bank_pol,
   input  logic                     adv,
   input  logic                     we_n,
   input  logic [LANES-1:0]         be_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES*LANE_W-1:0]  din,
   output logic [LANES*LANE_W-1:0]  dout,
   output logic                     dout_oe,
   output logic                     echo_en
);
   localparam int DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dlw_sram: ADDR_W must be at least 2 for four-beat bursts");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("dlw_sram: LANES and LANE_W must be positive");
      end
      if (BANKS < 1) begin : g_bad_bank
         $error("dlw_sram: BANKS must be positive");
      end
   endgenerate

   logic              bank_ok;
   dlw_op_e           cur_op;
   logic [ADDR_W-1:0] cur_addr;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_lane;
   logic [DATA_W-1:0] rd_arr;
   logic [DATA_W-1:0] rd_merged;
   logic [DATA_W-1:0] dout_q;
   logic              oe_q;
   logic              echo_q;

   assign bank_ok = (bank_sel == bank_pol);

   dlw_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .bank_ok  (bank_ok),
      .adv      (adv),
      .we_n     (we_n),
      .addr_in  (addr),
      .cur_op   (cur_op),
      .cur_addr (cur_addr)
   );

   dlw_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (cur_op == OP_WRITE),
      .addr_in (cur_addr),
      .be_n_in (be_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_lane (wr_lane)
   );

   dlw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wlane (wr_lane),
      .wdata (din),
      .raddr (cur_addr),
      .rdata (rd_arr)
   );

   // Same-edge forwarding of late write data into a coinciding read
   generate
      if (BYPASS) begin : g_bypass
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign rd_merged[i*LANE_W +: LANE_W] =
               (wr_en && wr_lane[i] && (wr_addr == cur_addr)) ?
                  din[i*LANE_W +: LANE_W] : rd_arr[i*LANE_W +: LANE_W];
         end
      end else begin : g_direct
         assign rd_merged = rd_arr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= 1'b0;
         echo_q <= 1'b0;
      end else begin
         oe_q   <= (cur_op == OP_READ);
         echo_q <= (cur_op != OP_BDES);
         if (cur_op == OP_READ) dout_q <= rd_merged;
      end
   end

   assign dout    = dout_q;
   assign dout_oe = oe_q;
   assign echo_en = echo_q;
endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk #(
   parameter int BANKS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic [BANKS-1:0] bank_sel,
   input logic [BANKS-1:0] bank_pol,
   input logic             adv,
   input logic             we_n,
   input logic             dout_oe,
   input logic             echo_en
);
   logic match;
   assign match = (bank_sel == bank_pol);

   p_bank_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !match) |=> (!echo_en && !dout_oe));

   p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && match && cs_n) |=> (!dout_oe && echo_en));

   p_read_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && match && !cs_n && we_n) |=> (dout_oe && echo_en));

   p_write_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && match && !cs_n && !we_n) |=> (!dout_oe && echo_en));

   p_cont_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ($stable(dout_oe) && $stable(echo_en)));
endmodule

bind dlw_sram dlw_sram_chk #(.BANKS(BANKS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .bank_sel (bank_sel),
   .bank_pol (bank_pol),
   .adv      (adv),
   .we_n     (we_n),
   .dout_oe  (dout_oe),
   .echo_en  (echo_en)
);

// File: tb/tb_dlw_sram.sv
module tb_dlw_sram;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cs_n;
   logic [1:0]    bank_sel, bank_pol;
   logic          adv, we_n;
   logic [NL-1:0] be_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dout_oe, echo_en;

   int n_tests = 0;
   int n_fail  = 0;
   int ncyc    = 0;

   // reference model state (0 bank deselect, 1 deselect, 2 read, 3 write)
   logic [DW-1:0] ref_mem [1 << AW];
   int            m_op;
   logic [AW-1:0] m_addr;
   logic          p1v, p2v;
   logic [AW-1:0] p1a, p2a;
   logic [NL-1:0] p1l, p2l;

   always #4 clk = ~clk;

   dlw_sram dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bank_sel(bank_sel),
      .bank_pol(bank_pol), .adv(adv), .we_n(we_n), .be_n(be_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .echo_en(echo_en)
   );

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int c);
      logic [LW-1:0] l;
      l = LW'(c * 37 + 11);
      return {l ^ 9'h0A5, l ^ 9'h13C, l ^ 9'h1F0, l} ^ {DW{1'b0}};
   endfunction

   task automatic step(input logic cs, input logic [1:0] bs,
                       input logic [1:0] bp, input logic a_adv,
                       input logic we, input logic [NL-1:0] be,
                       input logic [AW-1:0] a, input string tag);
      logic          exp_oe, exp_echo, rd;
      logic [DW-1:0] exp_d;
      cs_n = cs; bank_sel = bs; bank_pol = bp; adv = a_adv;
      we_n = we; be_n = be; addr = a; din = pat(ncyc);
      if (!a_adv) begin
         m_addr = a;
         if (bs != bp)   m_op = 0;
         else if (cs)    m_op = 1;
         else if (we)    m_op = 2;
         else            m_op = 3;
      end else begin
         m_addr = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
      end
      if (p2v)
         for (int i = 0; i < NL; i++)
            if (p2l[i]) ref_mem[p2a][i*LW +: LW] = din[i*LW +: LW];
      rd       = (m_op == 2);
      exp_oe   = rd;
      exp_echo = (m_op != 0);
      exp_d    = ref_mem[m_addr];
      p2v = p1v; p2a = p1a; p2l = p1l;
      p1v = (m_op == 3) && (|(~be));
      p1a = m_addr; p1l = ~be;
      @(negedge clk);
      ncyc++;
      check(tag, {35'd0, dout_oe}, {35'd0, exp_oe});
      check(tag, {35'd0, echo_en}, {35'd0, exp_echo});
      if (rd) check(tag, dout, exp_d);
   endtask

   task automatic idle(input string tag);
      step(1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, '0, tag);
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; bank_sel = 0; bank_pol = 0; adv = 0;
      we_n = 1'b1; be_n = '1; addr = '0; din = '0;
      m_op = 0; m_addr = '0; p1v = 0; p2v = 0; p1a = '0; p2a = '0;
      p1l = '0; p2l = '0;
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset values, then a continue acts as bank deselect
      check("R10", {35'd0, dout_oe}, 36'd0);
      check("R10", {35'd0, echo_en}, 36'd0);
      step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 4'h0, '0, "R10");

      // R4 R7: fill the whole array with write bursts
      for (int b = 0; b < (1 << AW) / 4; b++) begin
         step(1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 4'h0, AW'(b * 4), "R4");
         for (int c = 0; c < 3; c++)
            step(1'b0, 2'b01, 2'b01, 1'b1, 1'b0, 4'h0, '0, "R7");
      end
      idle("R2"); idle("R2");

      // R7 R3: read back in bursts from an offset base, fourth continue wraps
      for (int b = 0; b < (1 << AW) / 4; b++) begin
         step(1'b0, 2'b10, 2'b10, 1'b0, 1'b1, 4'hF, AW'(b * 4 + (b % 4)), "R3");
         for (int c = 0; c < 4; c++)
            step(1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 4'hF, '0, "R7");
      end

      // R5 R6: every lane mask on one word, read back after data capture
      for (int m = 0; m < 16; m++) begin
         step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, NL'(m), 6'd5, (m == 15) ? "R6" : "R5");
         idle("R2"); idle("R2");
         step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd5, (m == 15) ? "R6" : "R5");
      end
      // R6: aborted write continue still advances the address
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'h0, 6'd8, "R6");
      step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 4'hF, 6'd0, "R6");
      step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 4'h6, 6'd0, "R6");
      idle("R2"); idle("R2");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd8, "R6");
      step(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 4'hF, 6'd0, "R6");
      step(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 4'hF, 6'd0, "R6");

      // R9: read on the capture edge sees new data; earlier read sees old
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'h0, 6'd20, "R9");
      idle("R9");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd20, "R9");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 4'h5, 6'd21, "R9");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd21, "R9");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd21, "R9");
      step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 4'hF, 6'd21, "R9");

      // R1 R2 R3 R8: every select/polarity combination, with chip enable both ways
      for (int v = 0; v < 32; v++) begin
         logic [1:0] bs, bp;
         logic       cs;
         bs = v[1:0]; bp = v[3:2]; cs = v[4];
         step(cs, bs, bp, 1'b0, 1'b1, 4'hF, AW'(v * 3),
              (bs != bp) ? "R1" : (cs ? "R2" : "R3"));
         step(1'b0, 2'b00, 2'b11, 1'b1, 1'b1, 4'hF, '0, "R8");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule